// File: doc/BRIEF.md
# Stable Rank-Counting Sorter

This block ranks a short list of fixed-width keys for a stable sort. It does not return a sorted list. For each input position it returns the index at which that element belongs in the sorted order. A host can then move whole records into place using these indices. Equal keys keep their original relative order.

Operation has three phases:

- **Load:** after a `start` pulse, the block captures `N` keys, one on each cycle that `key_valid` is high.
- **Scan:** the block steps through the stored keys one at a time. One comparator lane per position looks at the scanned key on every step. A lane adds one to its counter when the scanned key is smaller than its own key, or equal to it and at an earlier position.
- **Emit:** the block presents the finished counts in position order, one per cycle. The final count is flagged, and a `done` pulse follows it.

With `SPLIT` set to 1, the scan is divided into two nearly equal halves. Each lane keeps two partial counters that advance together, one per half, and adds them at the output. This cuts the scan to ceil(N/2) cycles.

Top module: `stable_rank_sorter`

## Requirements
- R1: After reset, `busy`, `rank_valid`, `rank_last` and `done` are all low. While `busy` is low, `rank_valid` and `done` stay low.
- R2: A `start` seen while idle begins a load. The next `N` cycles with `key_valid` high store keys for positions 0 to N-1 in that order. Cycles with `key_valid` low do not advance the load. `key_valid` while idle or during scan is ignored.
- R3: The rank of position i equals the number of keys strictly smaller than key i, plus the number of keys equal to key i at positions below i. Keys are unsigned.
- R4: Equal keys get ranks that increase with their position, so a list of identical keys yields ranks 0, 1, ..., N-1.
- R5: Ranks appear on `rank_out` with `rank_valid` high for exactly N consecutive cycles, in position order 0 to N-1. `rank_last` is high only together with the rank of position N-1.
- R6: The N ranks of one list are all distinct and together form a permutation of 0..N-1.
- R7: `done` is high for exactly one cycle, in the cycle after `rank_last`. In the cycle after that, `busy` is low.
- R8: A `start` while `busy` is high has no effect. The load in progress and its ranks are unchanged.
- R9: With `SPLIT`=1, the ranks are identical to those of the single-scan mode. For odd N, the second half's last step is masked.
- R10: The first rank appears exactly SCAN_LEN+1 cycles after the cycle in which the last key is presented. SCAN_LEN is N when `SPLIT`=0 and ceil(N/2) when `SPLIT`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new list; honoured only while idle |
| key_valid | input | 1 | `key_in` holds the next key during load |
| key_in | input | KEY_W | Key value, unsigned |
| busy | output | 1 | High from the cycle after start until the done cycle inclusive |
| rank_valid | output | 1 | `rank_out` holds the rank of the current position |
| rank_out | output | $clog2(N) | Destination index of the current position |
| rank_last | output | 1 | Marks the rank of position N-1 |
| done | output | 1 | One-cycle pulse after the last rank |

## Verification
The bound checker watches the output framing on every cycle:
- the N ranks of a list are distinct;
- `rank_valid` runs without gaps until `rank_last`, which lands on the N-th rank;
- `done` follows `rank_last` for a single cycle;
- the block stays quiet while idle;
- `busy` is held through a run even when `start` is pulsed again.

The ranks' actual values cannot be checked that way, because they depend on the whole list. The same holds for stability among duplicates, agreement between the split and single-scan modes, the rejection of stray `key_valid` and `start`, and scan latency. These are shown by the bench's scenarios. Each scenario compares against ranks computed from the definition.

// File: rtl/rank_sorter_pkg.sv
package rank_sorter_pkg;

   // Sequencer phases of one sort run
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LOAD = 3'd1,
      ST_SCAN = 3'd2,
      ST_EMIT = 3'd3,
      ST_FIN  = 3'd4
   } sort_state_t;

   // Number of scan steps for a list length and scan variant
   function automatic int scan_steps(input int n, input int split);
      return (split != 0) ? (n + 1) / 2 : n;
   endfunction

endpackage

// File: rtl/rsort_keybank.sv
module rsort_keybank #(
   parameter int N     = 8,
   parameter int KEY_W = 16,
   parameter int IDX_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [KEY_W-1:0]            wr_key,
   output logic [N-1:0][KEY_W-1:0]     keys
);

   // One register per list position, each with its own decoded write enable
   for (genvar e = 0; e < N; e++) begin : g_entry
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);
      logic [KEY_W-1:0] slot_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (wr_en && (wr_idx == SLOT)) begin
            slot_q <= wr_key;
         end
      end

      assign keys[e] = slot_q;
   end

endmodule

// File: rtl/rsort_lane.sv
module rsort_lane #(
   parameter int KEY_W = 16,
   parameter int IDX_W = 3,
   parameter int CNT_W = 3,
   parameter int POS   = 0,
   parameter int SPLIT = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               en,
   input  logic [KEY_W-1:0]   own_key,
   input  logic [KEY_W-1:0]   key_a,
   input  logic [IDX_W-1:0]   idx_a,
   input  logic [KEY_W-1:0]   key_b,
   input  logic [IDX_W:0]     idx_b,
   input  logic               b_valid,
   output logic [CNT_W-1:0]   rank
);

   localparam logic [IDX_W:0] MY_POS = (IDX_W+1)'(POS);

   // A scanned key precedes this lane when it is smaller, or equal and earlier
   logic hit_a;
   assign hit_a = (key_a < own_key) ||
                  ((key_a == own_key) && ({1'b0, idx_a} < MY_POS));

   logic [CNT_W-1:0] cnt_a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_a_q <= '0;
      end else if (clr) begin
         cnt_a_q <= '0;
      end else if (en && hit_a) begin
         cnt_a_q <= cnt_a_q + CNT_W'(1);
      end
   end

   if (SPLIT != 0) begin : g_two_half
      logic             hit_b;
      logic [CNT_W-1:0] cnt_b_q;

      assign hit_b = b_valid &&
                     ((key_b < own_key) ||
                      ((key_b == own_key) && (idx_b < MY_POS)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_b_q <= '0;
         end else if (clr) begin
            cnt_b_q <= '0;
         end else if (en && hit_b) begin
            cnt_b_q <= cnt_b_q + CNT_W'(1);
         end
      end

      // Partial counts of the two halves combine into the final index
      assign rank = cnt_a_q + cnt_b_q;
   end else begin : g_one_scan
      logic unused_b;
      assign unused_b = ^{key_b, idx_b, b_valid};
      assign rank     = cnt_a_q;
   end

endmodule

// File: rtl/rsort_ctrl.sv
module rsort_ctrl
   import rank_sorter_pkg::*;
#(
   parameter int N        = 8,
   parameter int SCAN_LEN = 8,
   parameter int IDX_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              key_valid,
   output logic              clr,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              scan_en,
   output logic [IDX_W-1:0]  scan_idx,
   output logic              emit_valid,
   output logic [IDX_W-1:0]  emit_idx,
   output logic              emit_last,
   output logic              done,
   output logic              busy
);

   localparam logic [IDX_W-1:0] LAST_POS  = IDX_W'(N - 1);
   localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(SCAN_LEN - 1);

   sort_state_t      state_q;
   logic [IDX_W-1:0] ld_q;
   logic [IDX_W-1:0] sc_q;
   logic [IDX_W-1:0] em_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ld_q    <= '0;
         sc_q    <= '0;
         em_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_LOAD;
                  ld_q    <= '0;
               end
            end
            ST_LOAD: begin
               if (key_valid) begin
                  if (ld_q == LAST_POS) begin
                     state_q <= ST_SCAN;
                     sc_q    <= '0;
                  end else begin
                     ld_q <= ld_q + IDX_W'(1);
                  end
               end
            end
            ST_SCAN: begin
               if (sc_q == LAST_STEP) begin
                  state_q <= ST_EMIT;
                  em_q    <= '0;
               end else begin
                  sc_q <= sc_q + IDX_W'(1);
               end
            end
            ST_EMIT: begin
               if (em_q == LAST_POS) begin
                  state_q <= ST_FIN;
               end else begin
                  em_q <= em_q + IDX_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign clr        = (state_q == ST_IDLE) && start;
   assign wr_en      = (state_q == ST_LOAD) && key_valid;
   assign wr_idx     = ld_q;
   assign scan_en    = (state_q == ST_SCAN);
   assign scan_idx   = sc_q;
   assign emit_valid = (state_q == ST_EMIT);
   assign emit_idx   = em_q;
   assign emit_last  = (state_q == ST_EMIT) && (em_q == LAST_POS);
   assign done       = (state_q == ST_FIN);
   assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/stable_rank_sorter.sv
module stable_rank_sorter
   import rank_sorter_pkg::*;
#(
   parameter int   N      = 8,
   parameter int   KEY_W  = 16,
   parameter int   SPLIT  = 0,
   localparam int  RANK_W = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               key_valid,
   input  logic [KEY_W-1:0]   key_in,
   output logic               busy,
   output logic               rank_valid,
   output logic [RANK_W-1:0]  rank_out,
   output logic               rank_last,
   output logic               done
);

   localparam int IDX_W    = RANK_W;
   localparam int SCAN_LEN = scan_steps(N, SPLIT);

   // Elaboration-time parameter checks
   if (N < 3 || N > 64) begin : g_bad_len
      $error("stable_rank_sorter: N must lie in 3..64");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("stable_rank_sorter: KEY_W must be positive");
   end
   if (SPLIT != 0 && SPLIT != 1) begin : g_bad_split
      $error("stable_rank_sorter: SPLIT must be 0 or 1");
   end

   logic                       clr;
   logic                       wr_en;
   logic [IDX_W-1:0]           wr_idx;
   logic                       scan_en;
   logic [IDX_W-1:0]           scan_idx;
   logic [IDX_W-1:0]           emit_idx;
   logic [N-1:0][KEY_W-1:0]    keys;
   logic [N-1:0][RANK_W-1:0]   ranks;

   rsort_ctrl #(
      .N        (N),
      .SCAN_LEN (SCAN_LEN),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .key_valid  (key_valid),
      .clr        (clr),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .scan_en    (scan_en),
      .scan_idx   (scan_idx),
      .emit_valid (rank_valid),
      .emit_idx   (emit_idx),
      .emit_last  (rank_last),
      .done       (done),
      .busy       (busy)
   );

   rsort_keybank #(
      .N     (N),
      .KEY_W (KEY_W),
      .IDX_W (IDX_W)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_key (key_in),
      .keys   (keys)
   );

   // Broadcast of the scanned key(s) to every lane
   logic [KEY_W-1:0] key_a;
   logic [IDX_W:0]   idx_b;
   logic             b_valid;
   logic [KEY_W-1:0] key_b;

   assign key_a = keys[scan_idx];

   if (SPLIT != 0) begin : g_half_src
      assign idx_b   = {1'b0, scan_idx} + (IDX_W+1)'(SCAN_LEN);
      assign b_valid = (idx_b < (IDX_W+1)'(N));
      assign key_b   = b_valid ? keys[idx_b[IDX_W-1:0]] : '0;
   end else begin : g_no_half
      assign idx_b   = '0;
      assign b_valid = 1'b0;
      assign key_b   = '0;
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      rsort_lane #(
         .KEY_W (KEY_W),
         .IDX_W (IDX_W),
         .CNT_W (RANK_W),
         .POS   (i),
         .SPLIT (SPLIT)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .en      (scan_en),
         .own_key (keys[i]),
         .key_a   (key_a),
         .idx_a   (scan_idx),
         .key_b   (key_b),
         .idx_b   (idx_b),
         .b_valid (b_valid),
         .rank    (ranks[i])
      );
   end

   assign rank_out = ranks[emit_idx];

endmodule

// File: rtl/rank_sorter_chk.sv
module rank_sorter_chk #(
   parameter int  N      = 8,
   localparam int RANK_W = $clog2(N)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              rank_valid,
   input logic [RANK_W-1:0] rank_out,
   input logic              rank_last,
   input logic              done
);

   logic [(1<<RANK_W)-1:0] seen_q;
   logic [RANK_W-1:0]      emit_cnt_q;
   logic                   unused_start;

   assign unused_start = start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= '0;
         emit_cnt_q <= '0;
      end else if (done) begin
         seen_q     <= '0;
         emit_cnt_q <= '0;
      end else if (rank_valid) begin
         seen_q[rank_out] <= 1'b1;
         emit_cnt_q       <= emit_cnt_q + RANK_W'(1);
      end
   end

   AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      rank_valid |-> !seen_q[rank_out]); // R6
   AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      rank_valid |-> (rank_last == (emit_cnt_q == RANK_W'(N - 1)))); // R5
   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rank_last |-> rank_valid); // R5
   AST_EMIT_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rank_valid && !rank_last) |=> rank_valid); // R5
   AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rank_last |=> (done && !rank_valid)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R7
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rank_valid && !done && !rank_last)); // R1
   AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R8

endmodule

bind stable_rank_sorter rank_sorter_chk #(.N(N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .rank_valid (rank_valid),
   .rank_out   (rank_out),
   .rank_last  (rank_last),
   .done       (done)
);

// File: tb/stable_rank_sorter_tb.sv
`timescale 1ns/1ps
module stable_rank_sorter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        key_valid = 1'b0;
   logic [15:0] key_in = '0;

   logic       bz0, rv0, rl0, dn0;
   logic [2:0] ro0;
   logic       bz1, rv1, rl1, dn1;
   logic [2:0] ro1;
   logic       bz2, rv2, rl2, dn2;
   logic [2:0] ro2;

   int nchk  = 0;
   int nfail = 0;
   int cyc   = 0;
   int t_last [3];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Single-scan, N=8
   stable_rank_sorter #(.N(8), .KEY_W(16), .SPLIT(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .key_valid(key_valid), .key_in(key_in),
      .busy(bz0), .rank_valid(rv0), .rank_out(ro0), .rank_last(rl0), .done(dn0));
   // Split scan, N=8
   stable_rank_sorter #(.N(8), .KEY_W(16), .SPLIT(1)) u_dut_h (
      .clk(clk), .rst_n(rst_n), .start(start), .key_valid(key_valid), .key_in(key_in),
      .busy(bz1), .rank_valid(rv1), .rank_out(ro1), .rank_last(rl1), .done(dn1));
   // Split scan, odd N=7 (takes the first seven keys of each stream)
   stable_rank_sorter #(.N(7), .KEY_W(16), .SPLIT(1)) u_dut_o (
      .clk(clk), .rst_n(rst_n), .start(start), .key_valid(key_valid), .key_in(key_in),
      .busy(bz2), .rank_valid(rv2), .rank_out(ro2), .rank_last(rl2), .done(dn2));

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_rank(input logic [15:0] ks [8], input int n, input int i);
      int r = 0;
      for (int j = 0; j < n; j++)
         if (ks[j] < ks[i] || (ks[j] == ks[i] && j < i)) r++;
      return r;
   endfunction

   task automatic feed(input logic [15:0] ks [8], input bit gaps, input bit poke);
      if (gaps) begin
         key_valid = 1'b1;          // stray key while idle (R2)
         key_in    = 16'h0000;
         @(negedge clk);
      end
      key_valid = 1'b0;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (gaps && (k % 2 == 1)) begin
            key_valid = 1'b0;
            key_in    = 16'hFFFF;
            @(negedge clk);
         end
         key_valid = 1'b1;
         key_in    = ks[k];
         if (poke && k == 3) start = 1'b1;   // ignored restart (R8)
         if (k == 6) t_last[2] = cyc;
         if (k == 7) begin t_last[0] = cyc; t_last[1] = cyc; end
         @(negedge clk);
         start = 1'b0;
      end
      key_valid = 1'b0;
   endtask

   task automatic collect(input int which, input logic [15:0] ks [8], input string tag);
      int    n    = (which == 2) ? 7 : 8;
      int    slen = (which == 0) ? 8 : 4;
      string rtag = (which == 0) ? tag : "R9";
      int    e    = 0;
      int    mask = 0;
      logic  v, l, d, b;
      logic [2:0] r;
      while (e < n) begin
         @(negedge clk);
         case (which)
            0:       begin v = rv0; r = ro0; l = rl0; end
            1:       begin v = rv1; r = ro1; l = rl1; end
            default: begin v = rv2; r = ro2; l = rl2; end
         endcase
         if (v) begin
            if (e == 0) chk("R10", $sformatf("dut%0d first-rank latency", which),
                            cyc - t_last[which], slen + 1);
            chk(rtag, $sformatf("dut%0d rank pos %0d", which, e), int'(r), ref_rank(ks, n, e));
            chk("R5", $sformatf("dut%0d last flag pos %0d", which, e), int'(l), int'(e == n - 1));
            mask = mask | (1 << r);
            e++;
         end
      end
      chk("R6", $sformatf("dut%0d rank set", which), mask, (1 << n) - 1);
      @(negedge clk);
      case (which)
         0:       begin d = dn0; v = rv0; end
         1:       begin d = dn1; v = rv1; end
         default: begin d = dn2; v = rv2; end
      endcase
      chk("R7", $sformatf("dut%0d done after last", which), int'(d), 1);
      chk("R5", $sformatf("dut%0d valid after last", which), int'(v), 0);
      @(negedge clk);
      case (which)
         0:       begin d = dn0; b = bz0; end
         1:       begin d = dn1; b = bz1; end
         default: begin d = dn2; b = bz2; end
      endcase
      chk("R7", $sformatf("dut%0d done width", which), int'(d), 0);
      chk("R7", $sformatf("dut%0d busy after done", which), int'(b), 0);
   endtask

   task automatic run_case(input logic [15:0] ks [8], input bit gaps, input bit poke,
                           input string tag);
      fork
         feed(ks, gaps, poke);
         collect(0, ks, tag);
         collect(1, ks, tag);
         collect(2, ks, tag);
      join
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1", "busy after reset", int'({bz0, bz1, bz2}), 0);
      chk("R1", "rank_valid after reset", int'({rv0, rv1, rv2}), 0);
      chk("R1", "rank_last after reset", int'({rl0, rl1, rl2}), 0);
      chk("R1", "done after reset", int'({dn0, dn1, dn2}), 0);
   endtask

   task automatic t_example;   // R3: mixed keys with one duplicate pair
      logic [15:0] ks [8] = '{16'd1, 16'd3, 16'd8, 16'd5, 16'd6, 16'd7, 16'd2, 16'd5};
      run_case(ks, 1'b0, 1'b0, "R3");
      chk("R3", "example pos2 rank", ref_rank(ks, 8, 2), 7);
   endtask

   task automatic t_all_equal; // R4: identical keys keep position order
      logic [15:0] ks [8] = '{default: 16'd9};
      run_case(ks, 1'b0, 1'b0, "R4");
   endtask

   task automatic t_descending; // R3: fully reversed input
      logic [15:0] ks [8] = '{16'd800, 16'd700, 16'd600, 16'd500,
                              16'd400, 16'd300, 16'd200, 16'd100};
      run_case(ks, 1'b0, 1'b0, "R3");
   endtask

   task automatic t_extremes_gaps; // R2 + R3: key range ends, gapped load, stray idle key
      logic [15:0] ks [8] = '{16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000,
                              16'h8000, 16'h0001, 16'hFFFE, 16'h0000};
      run_case(ks, 1'b1, 1'b0, "R2");
   endtask

   task automatic t_restart_ignored; // R8: start during load is dropped
      logic [15:0] ks [8] = '{16'd4, 16'd4, 16'd2, 16'd9, 16'd1, 16'd4, 16'd0, 16'd7};
      run_case(ks, 1'b0, 1'b1, "R8");
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_example();
      t_all_equal();
      t_descending();
      t_extremes_gaps();
      t_restart_ignored();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

endmodule